// File: doc/BRIEF.md
# Daisy-Chained FIFO Stage with Token Passing

This block is one stage of a FIFO that can be made deeper by chaining several identical stages in a ring. Each stage holds a small storage array and two ownership tokens: a write token and a read token. All stages share the write strobe, read strobe and write data. Only the stage holding the write token stores the data. Only the stage holding the read token returns data. Each stage's read data is forced to zero while its output enable is low, so the outputs of all stages can be OR-ed together.

When a stage accepts a write into its last location, it raises a write-pass pulse on its expansion output in the same cycle and gives up the write token. The next stage in the ring takes the token at that clock edge. Reads pass the read token the same way. Data therefore fills and drains the stages in ring order, and the chain behaves as one FIFO whose capacity is the number of stages times the depth of one stage. A strap marks the first stage. After reset that stage owns both tokens.

When the mode strap selects single-device operation, the stage always owns both tokens and runs as a stand-alone FIFO. The expansion output then carries a half-full flag. The first-load pin becomes an active-low retransmit request that rewinds the read side to location 0.

Top module: `fifo_xstage`

## Requirements
- R1: With `expand_i`=1, the stage whose `fl_rt_ni` is low owns both tokens and every other stage owns neither. Ownership is loaded at the first rising edge after `rst_ni` is released, and strobes sampled at that edge are ignored.
- R2: A write is accepted only if the stage owns the write token and holds fewer than DEPTH entries. Accepted data is stored at consecutive locations 0..DEPTH-1, wrapping back to 0.
- R3: A read is accepted only if the stage owns the read token and is not empty. The oldest entry appears on `data_o` with `rd_oe_o`=1 during the cycle after the accepting edge. At all other times `rd_oe_o`=0 and `data_o` is all zeros.
- R4: In expansion mode, `xo_o[0]` (write pass) is high during exactly the cycle in which an accepted write targets location DEPTH-1. The stage loses the write token at that edge.
- R5: In expansion mode, `xo_o[1]` (read pass) is high during exactly the cycle in which an accepted read takes location DEPTH-1. The stage loses the read token at that edge.
- R6: `xi_i[0]` high at a rising edge grants the write token, and `xi_i[1]` high grants the read token. A grant wins over a release at the same edge.
- R7: A ring of stages, each stage's `xi_i` driven by the previous stage's `xo_o`, returns data in write order across stage boundaries. It holds N*DEPTH entries, ignores writes while full, and gives no output for reads while empty.
- R8: With `expand_i`=0, the stage owns both tokens regardless of `xi_i`. `xo_o[1]` is 0, and `xo_o[0]` is 1 exactly when the occupancy exceeds DEPTH/2.
- R9: With `expand_i`=0, `fl_rt_ni` low at an edge sets the read location to 0 and the occupancy to the write location, leaving the write location unchanged. Strobes at that edge are ignored. This replays every write since reset when fewer than DEPTH writes have been made.
- R10: With `expand_i`=1, a low level on `fl_rt_ni` after the first edge has no effect on reads, writes or occupancy.
- R11: `rst_ni` low asynchronously clears the locations, the occupancy, both tokens and `rd_oe_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| expand_i | input | 1 | Mode strap: 1 = chained stage, 0 = single device |
| fl_rt_ni | input | 1 | First-stage strap (chained) or active-low retransmit (single) |
| wr_i | input | 1 | Write strobe, one write per cycle it is high |
| rd_i | input | 1 | Read strobe, one read per cycle it is high |
| data_i | input | DATA_W | Write data |
| data_o | output | DATA_W | Read data, zero while disabled |
| rd_oe_o | output | 1 | Read data valid / output enable |
| xi_i | input | 2 | Token grants from previous stage: bit0 write, bit1 read |
| xo_o | output | 2 | Token passes to next stage, or {0, half-full} in single mode |

## Verification
The hardest situation to reach from the ports is a token wrapping all the way around the ring while its old owner still holds unread data. This is the point where the chain is full and a stage's local full check must stop the shared write strobe. It only arises after a long uneven run of writes and reads. The bench chains three stages of depth 4, so a wrap takes just twelve entries. It overfills the chain once in a directed burst and then runs a long random mix whose write probability shifts between phases, so that full and empty are each reached many times. A reference queue of capacity twelve predicts every pass pulse, every ignored strobe and every read word.

// File: rtl/fifo_xchain_pkg.sv
package fifo_xchain_pkg;
  localparam int XO_WR = 0;
  localparam int XO_RD = 1;
  localparam int N_TOK = 2;
  typedef logic [N_TOK-1:0] tok_vec_t;
endpackage

// File: rtl/xstage_token.sv
module xstage_token (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expand_i,
  input  logic boot_i,
  input  logic first_i,
  input  logic grant_i,
  input  logic release_i,
  output logic own_o
);
  logic own_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        own_q <= 1'b0;
    else if (boot_i)    own_q <= first_i;
    else if (grant_i)   own_q <= 1'b1;
    else if (release_i) own_q <= 1'b0;
  end

  // single device: stage always owns both sides
  assign own_o = expand_i ? own_q : 1'b1;
endmodule

// File: rtl/xstage_ptr.sv
module xstage_ptr #(
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          rewind_i,
  output logic [AW-1:0] ptr_o,
  output logic          last_o
);
  logic [AW-1:0] ptr_q;

  assign last_o = (ptr_q == AW'(DEPTH - 1));
  assign ptr_o  = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_q <= '0;
    else if (rewind_i) ptr_q <= '0;
    else if (step_i)   ptr_q <= last_o ? '0 : ptr_q + AW'(1);
  end
endmodule

// File: rtl/xstage_mem.sv
module xstage_mem #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 8,
  parameter int AW     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_oe_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] dout_q;
  logic              oe_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      oe_q   <= rd_en_i;
      dout_q <= rd_en_i ? mem_q[rd_addr_i] : '0;
    end
  end

  assign rd_data_o = oe_q ? dout_q : '0;
  assign rd_oe_o   = oe_q;
endmodule

// File: rtl/fifo_xstage.sv
module fifo_xstage
  import fifo_xchain_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              expand_i,
  input  logic              fl_rt_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              rd_oe_o,
  input  logic [1:0]        xi_i,
  output logic [1:0]        xo_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic          boot_q;
  tok_vec_t      own, pass, step, rewind, last;
  logic [AW-1:0] ptr [N_TOK];
  logic [CW-1:0] count_q;
  logic          own_w, own_r, full, empty, rt_acc, wr_acc, rd_acc, half;

  // first edge after reset loads ownership from the strap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) boot_q <= 1'b1;
    else         boot_q <= 1'b0;
  end

  assign own_w  = own[XO_WR];
  assign own_r  = own[XO_RD];
  assign full   = (count_q == CW'(DEPTH));
  assign empty  = (count_q == '0);
  assign rt_acc = !expand_i && !fl_rt_ni && !boot_q;
  assign wr_acc = wr_i && own_w && !full  && !boot_q && !rt_acc;
  assign rd_acc = rd_i && own_r && !empty && !boot_q && !rt_acc;

  assign step[XO_WR]   = wr_acc;
  assign step[XO_RD]   = rd_acc;
  assign rewind[XO_WR] = 1'b0;
  assign rewind[XO_RD] = rt_acc;
  assign pass[XO_WR]   = expand_i && wr_acc && last[XO_WR];
  assign pass[XO_RD]   = expand_i && rd_acc && last[XO_RD];

  for (genvar t = 0; t < N_TOK; t++) begin : g_side
    xstage_token u_tok (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .expand_i  (expand_i),
      .boot_i    (boot_q),
      .first_i   (!fl_rt_ni),
      .grant_i   (xi_i[t]),
      .release_i (pass[t]),
      .own_o     (own[t])
    );
    xstage_ptr #(.DEPTH(DEPTH), .AW(AW)) u_ptr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .step_i   (step[t]),
      .rewind_i (rewind[t]),
      .ptr_o    (ptr[t]),
      .last_o   (last[t])
    );
  end

  xstage_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_acc),
    .wr_addr_i (ptr[XO_WR]),
    .wr_data_i (data_i),
    .rd_en_i   (rd_acc),
    .rd_addr_i (ptr[XO_RD]),
    .rd_data_o (data_o),
    .rd_oe_o   (rd_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                count_q <= '0;
    else if (rt_acc)            count_q <= CW'(ptr[XO_WR]);
    else if (wr_acc && !rd_acc) count_q <= count_q + CW'(1);
    else if (rd_acc && !wr_acc) count_q <= count_q - CW'(1);
  end

  assign half = (count_q > CW'(DEPTH / 2));
  assign xo_o = expand_i ? pass : {1'b0, half};
endmodule

// File: rtl/fifo_xstage_chk.sv
module fifo_xstage_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          expand_i,
  input logic          rd_i,
  input logic          rd_oe_o,
  input logic          data_nz,
  input logic [1:0]    xi_i,
  input logic [1:0]    xo_o,
  input logic          own_w,
  input logic          own_r,
  input logic          boot_q,
  input logic [CW-1:0] count_q
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH)); // R2
  AST_OE_FROM_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_oe_o |-> $past(rd_i && own_r)); // R3
  AST_OE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_oe_o |-> !data_nz); // R3
  AST_WPASS_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expand_i && xo_o[0] && !xi_i[0] |=> !own_w); // R4
  AST_RPASS_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expand_i && xo_o[1] && !xi_i[1] |=> !own_r); // R5
  AST_GRANT_W: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expand_i && xi_i[0] && !boot_q |=> own_w); // R6
  AST_GRANT_R: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expand_i && xi_i[1] && !boot_q |=> own_r); // R6
  AST_SINGLE_XO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !expand_i |-> !xo_o[1] && own_w && own_r); // R8
  AST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expand_i |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + CW'(1))
                 || (count_q + CW'(1) == $past(count_q))); // R10
endmodule

bind fifo_xstage fifo_xstage_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .expand_i (expand_i),
  .rd_i     (rd_i),
  .rd_oe_o  (rd_oe_o),
  .data_nz  (|data_o),
  .xi_i     (xi_i),
  .xo_o     (xo_o),
  .own_w    (own_w),
  .own_r    (own_r),
  .boot_q   (boot_q),
  .count_q  (count_q)
);

// File: tb/tb_fifo_xstage.sv
module tb_fifo_xstage;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 9;
  localparam int D   = 4;
  localparam int NS  = 3;
  localparam int CAP = NS * D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          wr = 0, rd = 0, fl1 = 1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] q0, q1, q2;
  logic          oe0, oe1, oe2;
  logic [1:0]    xo0, xo1, xo2;

  logic          swr = 0, srd = 0, srt_n = 1;
  logic [DW-1:0] sdin = '0, sq;
  logic          soe;
  logic [1:0]    sxo;

  fifo_xstage #(.DATA_W(DW), .DEPTH(D)) dut (
    .clk_i(clk), .rst_ni(rst_n), .expand_i(1'b1), .fl_rt_ni(1'b0),
    .wr_i(wr), .rd_i(rd), .data_i(din), .data_o(q0), .rd_oe_o(oe0),
    .xi_i(xo2), .xo_o(xo0));
  fifo_xstage #(.DATA_W(DW), .DEPTH(D)) dut_s1 (
    .clk_i(clk), .rst_ni(rst_n), .expand_i(1'b1), .fl_rt_ni(fl1),
    .wr_i(wr), .rd_i(rd), .data_i(din), .data_o(q1), .rd_oe_o(oe1),
    .xi_i(xo0), .xo_o(xo1));
  fifo_xstage #(.DATA_W(DW), .DEPTH(D)) dut_s2 (
    .clk_i(clk), .rst_ni(rst_n), .expand_i(1'b1), .fl_rt_ni(1'b1),
    .wr_i(wr), .rd_i(rd), .data_i(din), .data_o(q2), .rd_oe_o(oe2),
    .xi_i(xo1), .xo_o(xo2));
  fifo_xstage #(.DATA_W(DW), .DEPTH(D)) dut_sg (
    .clk_i(clk), .rst_ni(rst_n), .expand_i(1'b0), .fl_rt_ni(srt_n),
    .wr_i(swr), .rd_i(srd), .data_i(sdin), .data_o(sq), .rd_oe_o(soe),
    .xi_i(2'b11), .xo_o(sxo));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [DW-1:0] mq[$];
  int wc = 0, rc = 0;
  bit pend_r = 0;
  logic [DW-1:0] pend_d = '0;

  logic [DW-1:0] sm[$];
  logic [DW-1:0] shist[$];
  bit spend = 0;
  logic [DW-1:0] spend_d = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] exp_xo(input bit ww, input bit rr, input int w_i, input int r_i);
    logic [5:0] v = '0;
    if (ww && (w_i % D == D - 1)) v[2 * ((w_i / D) % NS)]     = 1'b1;
    if (rr && (r_i % D == D - 1)) v[2 * ((r_i / D) % NS) + 1] = 1'b1;
    return v;
  endfunction

  task automatic chain_op(input bit w, input bit r, input logic [DW-1:0] d, input string tag);
    bit ww, rr;
    logic [5:0] ex;
    @(negedge clk);
    check($countones({oe0, oe1, oe2}) == (pend_r ? 1 : 0), "R3 enable", {oe2, oe1, oe0}, pend_r);
    if (pend_r) check((q0 | q1 | q2) == pend_d, tag, q0 | q1 | q2, pend_d);
    else        check((q0 | q1 | q2) == '0, "R3 idle data", q0 | q1 | q2, 0);
    wr = w; rd = r; din = d;
    ww = w && (mq.size() < CAP);
    rr = r && (mq.size() > 0);
    ex = exp_xo(ww, rr, wc, rc);
    #1;
    check({xo2, xo1, xo0} == ex, "R4 R5 pass pulses", {xo2, xo1, xo0}, ex);
    pend_r = rr;
    if (rr) begin pend_d = mq.pop_front(); rc++; end
    if (ww) begin mq.push_back(d); wc++; end
  endtask

  task automatic s_op(input bit w, input bit r, input bit rt, input logic [DW-1:0] d, input string tag);
    bit ww, rr;
    @(negedge clk);
    check(soe == spend, "R3 single enable", soe, spend);
    if (spend) check(sq == spend_d, tag, sq, spend_d);
    check(sxo == {1'b0, sm.size() > D / 2}, "R8 half flag", sxo, {1'b0, sm.size() > D / 2});
    swr = w; srd = r; srt_n = !rt; sdin = d;
    spend = 0;
    if (rt) begin
      sm = shist;
    end else begin
      ww = w && (sm.size() < D);
      rr = r && (sm.size() > 0);
      spend = rr;
      if (rr) spend_d = sm.pop_front();
      if (ww) begin sm.push_back(d); shist.push_back(d); end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr = 0; rd = 0; swr = 0; srd = 0; srt_n = 1;
    #1;
    check({oe0, oe1, oe2, soe} == 4'b0, "R11 enable cleared", {oe0, oe1, oe2, soe}, 0);
    check({xo0, xo1, xo2} == 6'b0, "R11 no pulses", {xo0, xo1, xo2}, 0);
    mq.delete(); sm.delete(); shist.delete();
    wc = 0; rc = 0; pend_r = 0; spend = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    // R1: strobe at the boot edge is ignored
    wr = 1; din = 9'h1AA;
    @(negedge clk);
    wr = 0;
    chain_op(0, 1, 0, "R1");
    chain_op(0, 0, 0, "R1");
    check(!(oe0 | oe1 | oe2), "R1 boot write ignored", {oe0, oe1, oe2}, 0);

    // overfill then overdrain the ring (R2, R7)
    for (int i = 0; i < CAP + 3; i++) chain_op(1, 0, DW'(9'h040 + i), "R7");
    for (int i = 0; i < CAP + 3; i++) chain_op(0, 1, 0, "R7 order");
    chain_op(0, 0, 0, "R7");

    // random phases with shifting write bias; strap glitch on stage 1 (R10)
    for (int i = 0; i < 3000; i++) begin
      int bias = ((i / 300) % 2 == 0) ? 70 : 30;
      bit w = ($urandom % 100) < bias;
      bit r = ($urandom % 100) < (100 - bias);
      string tag = (i >= 1000 && i < 1100) ? "R10 data" : "R7 data";
      fl1 = !(i >= 1000 && i < 1100);
      chain_op(w, r, DW'($urandom), tag);
    end
    fl1 = 1;
    chain_op(0, 0, 0, "R7");

    // mid-run reset (R11) then the chain must read empty
    for (int i = 0; i < 5; i++) chain_op(1, 0, DW'(i), "R2");
    do_reset();
    chain_op(0, 1, 0, "R11");
    chain_op(0, 0, 0, "R11");

    // single device: half flag, retransmit, full block
    s_op(1, 0, 0, 9'h011, "R8");
    s_op(1, 0, 0, 9'h022, "R8");
    s_op(1, 0, 0, 9'h033, "R8");
    s_op(0, 1, 0, 0, "R8 data");
    s_op(0, 1, 0, 0, "R8 data");
    s_op(1, 1, 1, 9'h0EE, "R9");
    for (int i = 0; i < 5; i++) s_op(0, 1, 0, 0, "R9 replay");
    for (int i = 0; i < 7; i++) s_op(1, 0, 0, DW'(9'h100 + i), "R2 single full");
    for (int i = 0; i < 400; i++)
      s_op($urandom % 2, $urandom % 2, 0, DW'($urandom), "R8 random data");
    s_op(0, 0, 0, 0, "R8");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule